// File: doc/BRIEF.md
# Processing Element Watchdog Supervisor

This block watches a row of processing elements that share an ingress path and an egress bus. Each element has two independent countdown watchdogs. The compute watchdog bounds how long the element may spend on a job once its input has been fully delivered. The egress watchdog bounds how long the element may keep the shared output bus after the dispatcher has granted it. Software writes a cycle budget for each watchdog of each element through a small configuration port during start-up.

When a watchdog runs out, the block pulses that element's reset for one clock. In the same clock it raises a one-cycle drop flag, so the dispatcher can discard the job. Each element has its own lane, so a fault in one element never holds up or disturbs the supervision of the others. Filling in the discarded data happens elsewhere.

Top module: `pe_guard`

## Requirements
- R1: A configuration write (`cfg_we` high at a rising edge) stores `cfg_limit` as the budget of element `cfg_idx`. `cfg_kind` = 0 selects the compute budget and `cfg_kind` = 1 selects the egress budget. Reset clears every budget to zero.
- R2: A rising edge that samples `load_done[i]` high starts element i's compute watchdog with its compute budget L. If it is not stopped, `pe_rst[i]` goes high in the cycle that follows the L-th rising edge after the start edge.
- R3: A falling edge of `proc_run[i]` stops the compute watchdog. The fall is seen at the first rising edge that samples the low value after a high one. A stop seen at any edge up to and including the L-th edge after the start prevents the reset.
- R4: Each expiry produces a `pe_rst[i]` pulse exactly one cycle wide. `drop[i]` is high in that same cycle and in no other.
- R5: A rising edge that samples `data_ack[i]` high starts the egress watchdog with the egress budget L. A falling edge of `data_valid[i]` seen at or before the L-th edge after the start stops it. Without that fall, `pe_rst[i]` fires after the L-th edge, in the same way as in R2.
- R6: A new start while a watchdog is counting reloads its full budget. The expiry is then timed from the new start edge only.
- R7: An egress budget of zero disables that element's egress watchdog. With it, `data_ack` followed by a stuck `data_valid` never produces a reset.
- R8: When either watchdog of an element expires, the other watchdog of that element is cancelled. A fault yields one reset pulse, not two.
- R9: An expiry in one element leaves every other element's outputs low and its running watchdogs counting on their own schedule.
- R10: After reset all `pe_rst` and `drop` bits are low and no watchdog runs. With zero budgets, a start produces no reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Budget write strobe |
| cfg_kind | input | 1 | 0 = compute budget, 1 = egress budget |
| cfg_idx | input | IDX_W | Element selected by the write |
| cfg_limit | input | CNT_W | Budget in clock cycles |
| load_done | input | N_PE | Per element: input delivery finished, start compute watchdog |
| proc_run | input | N_PE | Per element: computation in progress |
| data_ack | input | N_PE | Per element: egress grant from dispatcher, start egress watchdog |
| data_valid | input | N_PE | Per element: element drives the egress bus |
| pe_rst | output | N_PE | Per element: one-cycle reset pulse on expiry |
| drop | output | N_PE | Per element: one-cycle flag marking the job as discarded |

## Verification
The assertions take the handshake inputs to be synchronous to `clk`. Start strobes may last any number of cycles, but each high sample counts as a fresh start. The egress watchdog treats only a high-to-low step of `data_valid` as completion. The bench drives every input on the falling clock edge and holds start strobes high for exactly one rising edge. It writes budgets only while the element concerned is idle, so every expected expiry edge follows directly from the start edge and the budget.

// File: rtl/pe_guard_pkg.sv
package pe_guard_pkg;

  typedef enum logic {
    LIM_PROC = 1'b0,
    LIM_BUS  = 1'b1
  } lim_kind_e;

endpackage

// File: rtl/pe_guard_limits.sv
module pe_guard_limits
  import pe_guard_pkg::*;
#(
  parameter int N_PE  = 5,
  parameter int CNT_W = 16,
  parameter int IDX_W = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cfg_we,
  input  logic                         cfg_kind,
  input  logic [IDX_W-1:0]             cfg_idx,
  input  logic [CNT_W-1:0]             cfg_limit,
  output logic [N_PE-1:0][CNT_W-1:0]   proc_lim,
  output logic [N_PE-1:0][CNT_W-1:0]   bus_lim
);

  for (genvar e = 0; e < N_PE; e++) begin : g_slot
    logic hit;
    assign hit = cfg_we && (cfg_idx == IDX_W'(e));

    always_ff @(posedge clk) begin
      if (rst) begin
        proc_lim[e] <= '0;
        bus_lim[e]  <= '0;
      end else if (hit) begin
        if (cfg_kind == LIM_BUS) bus_lim[e]  <= cfg_limit;
        else                     proc_lim[e] <= cfg_limit;
      end
    end
  end

endmodule

// File: rtl/pe_guard_timer.sv
module pe_guard_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             stop,
  input  logic             kill,
  input  logic [CNT_W-1:0] limit,
  output logic             expire,
  output logic             running
);

  logic [CNT_W-1:0] cnt;
  logic             act;

  // Expiry is the step from one to zero; a restart or stop in that cycle wins.
  assign expire  = act && (cnt == CNT_W'(1)) && !start && !stop;
  assign running = act;

  always_ff @(posedge clk) begin
    if (rst) begin
      act <= 1'b0;
      cnt <= '0;
    end else if (kill || expire) begin
      act <= 1'b0;
      cnt <= '0;
    end else if (start) begin
      act <= (limit != '0);
      cnt <= limit;
    end else if (stop) begin
      act <= 1'b0;
      cnt <= '0;
    end else if (act) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  // R2/R5: a free-running watchdog loses exactly one count per cycle
  p_count_down_r2: assert property (@(posedge clk) disable iff (rst)
    act && !start && !stop && !kill && (cnt > CNT_W'(1))
      |=> act && (cnt == $past(cnt) - CNT_W'(1)));

  // R7: a zero budget leaves the watchdog idle
  p_zero_idle_r7: assert property (@(posedge clk) disable iff (rst)
    start && !kill && (limit == '0) |=> !running);

  // R3: a stop without restart ends the count
  p_stop_clears_r3: assert property (@(posedge clk) disable iff (rst)
    act && stop && !start |=> !running);

endmodule

// File: rtl/pe_guard_lane.sv
module pe_guard_lane #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_done,
  input  logic             proc_run,
  input  logic             data_ack,
  input  logic             data_valid,
  input  logic [CNT_W-1:0] proc_lim,
  input  logic [CNT_W-1:0] bus_lim,
  output logic             pe_rst,
  output logic             drop
);

  logic run_q, valid_q;
  logic run_fall, valid_fall;
  logic p_exp, b_exp, p_run, b_run;

  assign run_fall   = run_q && !proc_run;
  assign valid_fall = valid_q && !data_valid;

  pe_guard_timer #(.CNT_W(CNT_W)) u_proc_t (
    .clk     (clk),
    .rst     (rst),
    .start   (load_done),
    .stop    (run_fall),
    .kill    (b_exp),
    .limit   (proc_lim),
    .expire  (p_exp),
    .running (p_run)
  );

  pe_guard_timer #(.CNT_W(CNT_W)) u_bus_t (
    .clk     (clk),
    .rst     (rst),
    .start   (data_ack),
    .stop    (valid_fall),
    .kill    (p_exp),
    .limit   (bus_lim),
    .expire  (b_exp),
    .running (b_run)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      valid_q <= 1'b0;
      pe_rst  <= 1'b0;
      drop    <= 1'b0;
    end else begin
      run_q   <= proc_run;
      valid_q <= data_valid;
      pe_rst  <= p_exp || b_exp;
      drop    <= p_exp || b_exp;
    end
  end

  // R4: reset pulse never lasts two cycles
  p_rst_single_r4: assert property (@(posedge clk) disable iff (rst)
    pe_rst |=> !pe_rst);

  // R8: a reset pulse only follows a cycle in which some watchdog was live
  p_rst_from_timer_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(pe_rst) |-> $past(p_run || b_run));

  // R8: after an expiry neither watchdog of this lane is still counting
  p_both_cleared_r8: assert property (@(posedge clk) disable iff (rst)
    (p_exp || b_exp) && !load_done && !data_ack |=> !p_run && !b_run);

endmodule

// File: rtl/pe_guard.sv
module pe_guard
  import pe_guard_pkg::*;
#(
  parameter int N_PE  = 5,
  parameter int CNT_W = 16,
  localparam int IDX_W = (N_PE > 1) ? $clog2(N_PE) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic             cfg_kind,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [CNT_W-1:0] cfg_limit,
  input  logic [N_PE-1:0]  load_done,
  input  logic [N_PE-1:0]  proc_run,
  input  logic [N_PE-1:0]  data_ack,
  input  logic [N_PE-1:0]  data_valid,
  output logic [N_PE-1:0]  pe_rst,
  output logic [N_PE-1:0]  drop
);

  logic [N_PE-1:0][CNT_W-1:0] proc_lim;
  logic [N_PE-1:0][CNT_W-1:0] bus_lim;

  pe_guard_limits #(
    .N_PE  (N_PE),
    .CNT_W (CNT_W),
    .IDX_W (IDX_W)
  ) u_limits (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_kind  (cfg_kind),
    .cfg_idx   (cfg_idx),
    .cfg_limit (cfg_limit),
    .proc_lim  (proc_lim),
    .bus_lim   (bus_lim)
  );

  for (genvar e = 0; e < N_PE; e++) begin : g_lane
    pe_guard_lane #(.CNT_W(CNT_W)) u_lane (
      .clk        (clk),
      .rst        (rst),
      .load_done  (load_done[e]),
      .proc_run   (proc_run[e]),
      .data_ack   (data_ack[e]),
      .data_valid (data_valid[e]),
      .proc_lim   (proc_lim[e]),
      .bus_lim    (bus_lim[e]),
      .pe_rst     (pe_rst[e]),
      .drop       (drop[e])
    );
  end

  // R10: nothing is flagged in the first cycle out of reset
  p_quiet_after_reset_r10: assert property (@(posedge clk)
    $past(rst) |-> (pe_rst == '0) && (drop == '0));

endmodule

// File: tb/pe_guard_bench.sv
`timescale 1ns/1ps
module pe_guard_bench;

  localparam int N  = 5;
  localparam int CW = 16;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst;
  logic          cfg_we;
  logic          cfg_kind;
  logic [IW-1:0] cfg_idx;
  logic [CW-1:0] cfg_limit;
  logic [N-1:0]  load_done, proc_run, data_ack, data_valid;
  logic [N-1:0]  pe_rst, drop;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  pe_guard #(.N_PE(N), .CNT_W(CW)) u_pe_guard (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .cfg_kind   (cfg_kind),
    .cfg_idx    (cfg_idx),
    .cfg_limit  (cfg_limit),
    .load_done  (load_done),
    .proc_run   (proc_run),
    .data_ack   (data_ack),
    .data_valid (data_valid),
    .pe_rst     (pe_rst),
    .drop       (drop)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge.
  task automatic cfg(input int kind, input int idx, input int lim);
    cfg_we = 1'b1; cfg_kind = kind[0]; cfg_idx = IW'(idx); cfg_limit = CW'(lim);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic start_proc(input int i);
    load_done[i] = 1'b1;
    @(negedge clk);
    load_done[i] = 1'b0;
  endtask

  task automatic start_bus(input int i);
    data_ack[i] = 1'b1;
    @(negedge clk);
    data_ack[i] = 1'b0;
  endtask

  // Checks cycles 1..lim after the start edge; fire says whether lim is an expiry.
  task automatic watch(input int i, input int lim, input bit fire, input string req);
    for (int c = 1; c < lim; c++) begin
      @(negedge clk);
      chk(pe_rst[i] == 1'b0 && drop[i] == 1'b0, req, "early pulse", int'(pe_rst[i]), 0);
    end
    @(negedge clk);
    chk(pe_rst[i] == fire, req, "pe_rst at budget end", int'(pe_rst[i]), int'(fire));
    chk(drop[i] == fire, req, "drop with reset (R4)", int'(drop[i]), int'(fire));
    if (fire) begin
      chk((pe_rst & ~(N'(1) << i)) == '0, "R9", "other lanes at expiry", int'(pe_rst), int'(N'(1) << i));
      @(negedge clk);
      chk(pe_rst[i] == 1'b0 && drop[i] == 1'b0, "R4", "pulse width", int'(pe_rst[i]), 0);
    end
  endtask

  task automatic quiet(input int i, input int n, input string req);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      chk(pe_rst[i] == 1'b0 && drop[i] == 1'b0, req, "unexpected pulse", int'(pe_rst[i]), 0);
    end
  endtask

  task automatic t_reset();
    chk(pe_rst == '0, "R10", "pe_rst after reset", int'(pe_rst), 0);
    chk(drop == '0, "R10", "drop after reset", int'(drop), 0);
    proc_run[0] = 1'b1;
    start_proc(0);
    quiet(0, 10, "R10");
    proc_run[0] = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_config();
    cfg(0, 0, 6); cfg(0, 1, 6); cfg(0, 2, 3); cfg(0, 4, 9);
    cfg(1, 1, 5); cfg(1, 2, 4); cfg(1, 3, 0);
  endtask

  task automatic t_proc_expire();
    proc_run[0] = 1'b1;
    start_proc(0);
    watch(0, 6, 1'b1, "R1 R2");
    proc_run[0] = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_proc_stop();
    proc_run[1] = 1'b1;
    start_proc(1);
    repeat (5) @(negedge clk);
    proc_run[1] = 1'b0;       // fall sampled at the sixth edge, the last one
    quiet(1, 10, "R3");
  endtask

  task automatic t_bus_expire();
    data_valid[2] = 1'b1;
    start_bus(2);
    watch(2, 4, 1'b1, "R5");
    data_valid[2] = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_bus_done();
    data_valid[1] = 1'b1;
    start_bus(1);
    repeat (4) @(negedge clk);
    data_valid[1] = 1'b0;     // fall sampled at the fifth edge
    quiet(1, 10, "R5");
  endtask

  task automatic t_bus_off();
    data_valid[3] = 1'b1;
    start_bus(3);
    quiet(3, 20, "R7");
    data_valid[3] = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_restart();
    proc_run[0] = 1'b1;
    start_proc(0);
    repeat (2) @(negedge clk);
    start_proc(0);            // restart three edges later
    watch(0, 6, 1'b1, "R6");
    proc_run[0] = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_isolation();
    proc_run[0] = 1'b1; proc_run[4] = 1'b1;
    load_done[0] = 1'b1; load_done[4] = 1'b1;
    @(negedge clk);
    load_done = '0;
    for (int c = 1; c <= 10; c++) begin
      @(negedge clk);
      chk(pe_rst[0] == (c == 6), "R9", "lane 0 timing", int'(pe_rst[0]), int'(c == 6));
      chk(pe_rst[4] == (c == 9), "R9", "lane 4 timing", int'(pe_rst[4]), int'(c == 9));
    end
    proc_run = '0;
    @(negedge clk);
  endtask

  task automatic t_cancel();
    cfg(1, 2, 10);
    proc_run[2] = 1'b1; data_valid[2] = 1'b1;
    load_done[2] = 1'b1; data_ack[2] = 1'b1;
    @(negedge clk);
    load_done[2] = 1'b0; data_ack[2] = 1'b0;
    for (int c = 1; c <= 15; c++) begin
      @(negedge clk);
      chk(pe_rst[2] == (c == 3), "R8", "single pulse on fault", int'(pe_rst[2]), int'(c == 3));
    end
    proc_run[2] = 1'b0; data_valid[2] = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #400000;
    total++;
    bad++;
    $display("FAIL watchdog: run did not finish actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1;
    cfg_we = 1'b0; cfg_kind = 1'b0; cfg_idx = '0; cfg_limit = '0;
    load_done = '0; proc_run = '0; data_ack = '0; data_valid = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_config();
    t_proc_expire();
    t_proc_stop();
    t_bus_expire();
    t_bus_done();
    t_bus_off();
    t_restart();
    t_isolation();
    t_cancel();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule